// File: doc/BRIEF.md
# Vector Prefix Detector and Element Loop Sequencer

This block sits between fetch and retire in a core that accepts a 64-bit prefixed vector instruction format. It looks at the leading 32-bit word of the instruction now at retire and decides whether that word is a vector prefix. When it is, the block pulls out the 24-bit remap field and widens the program-counter step from 4 to 8 bytes.

The block also keeps a 32-bit loop-state word. The word holds a maximum length, the active vector length (VL), a source element step, a destination element step, a sub-vector length and an auxiliary step. A prefixed instruction with a vector destination is run again at the same address, once per element. The source step counts the elements. The next-PC output stays on the current PC until the element at index VL−1 retires. A VL of zero makes the prefixed instruction a no-op that simply advances. A scalar destination ends the loop after one element.

The block has a software write port that replaces the whole loop-state word. That write wins over any loop update made in the same cycle.

Top module: `vec_prefix_seq`

## Requirements
- R1: `isPrefix` is 1 exactly when the word's six major-opcode bits equal 1 and word bits 7 and 9 are both 1. Bits are numbered big-endian: bit 0 is `instWord[31]` and bit n is `instWord[31-n]`, so the opcode is `instWord[31:26]`, bit 7 is `instWord[24]` and bit 9 is `instWord[22]`. `isPrefix` depends on the word only.
- R2: `remapField` is built from the word at all times, whether or not it is a prefix. Its MSB `remapField[23]` is big-endian bit 6 (`instWord[25]`). Next comes bit 8 (`instWord[23]`). Big-endian bits 10 to 31 (`instWord[21:0]`) fill `remapField[21:0]` in order.
- R3: When the PC is not being held, `nextPc` is `curPc + 8` for a prefix word and `curPc + 4` otherwise, modulo 2^PC_W.
- R4: A prefix word with VL = 0 gives `nextPc = curPc + 8`. A retire of that word leaves the loop state unchanged.
- R5: The loop repeats when the word is a prefix, VL ≠ 0, `destIsVector` = 1 and source step ≠ VL−1 (7-bit arithmetic). In that case `nextPc` equals `curPc`, and a retire increments the source step by 1.
- R6: Any other retire, apart from the VL = 0 case of R4, clears the source step to 0 and the PC advances by R3. This covers the last element, a scalar destination and a non-prefix word. The other fields keep their values.
- R7: The loop-state fields use big-endian bit numbering over `loopState`. Maximum length is bits 0–6 = [31:25], VL is bits 7–13 = [24:18], source step is bits 14–20 = [17:11], destination step is bits 21–27 = [10:4], sub-vector length is bits 28–29 = [3:2] and the auxiliary step is bits 30–31 = [1:0].
- R8: When `swWrEn` is 1, the next state equals `swWrData`, even if a loop update would happen in the same cycle.
- R9: A synchronous reset clears the loop state to 0 and takes priority over a software write. With neither a retire nor a write, the state holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instWord | input | 32 | Leading word of the instruction at retire |
| curPc | input | PC_W | Address of that instruction |
| retireValid | input | 1 | One element of the instruction retires this cycle |
| destIsVector | input | 1 | The instruction's destination is a vector |
| swWrEn | input | 1 | Software write strobe for the loop-state word |
| swWrData | input | 32 | Value for the software write |
| nextPc | output | PC_W | Address to fetch next |
| isPrefix | output | 1 | Word is a vector prefix |
| remapField | output | 24 | Extracted remap field |
| loopState | output | 32 | Current loop-state word |

## Verification
The detector is fed true prefixes, random words and near-miss words that are a prefix with exactly one identifying bit flipped. This separates a correct match from one that ignores a bit. The remap field is checked with alternating bit patterns, which expose any swap of the two isolated bits or a slip of the 22-bit run. The loop runs to completion for several VL values. It is also cut short by a scalar destination, skipped with VL = 0, and overwritten by software in the middle of an element. These runs separate hold from advance, increment from clear, and write priority from loop priority. A seeded random mix of all of these checks every cycle against a model in the bench.

// File: rtl/vec_prefix_pkg.sv
package vec_prefix_pkg;
  localparam int INST_W   = 32;
  localparam int FLD_W    = 7;
  localparam int SUB_W    = 2;
  localparam int RM_W     = 24;
  localparam int STATE_W  = 4 * FLD_W + 2 * SUB_W;
  localparam int OPC_W    = 6;
  localparam logic [OPC_W-1:0] PREFIX_OPC = 6'd1;

  typedef struct packed {
    logic [FLD_W-1:0] maxLen;
    logic [FLD_W-1:0] len;
    logic [FLD_W-1:0] srcStep;
    logic [FLD_W-1:0] dstStep;
    logic [SUB_W-1:0] subLen;
    logic [SUB_W-1:0] auxStep;
  } loopState_t;

  typedef struct packed {
    logic swLoad;
    logic stepInc;
    logic stepClear;
  } seqStrobe_t;

  // big-endian bit n of a word of width w sits at little-endian index w-1-n
  function automatic int beIdx(input int w, input int n);
    return w - 1 - n;
  endfunction

  // big-endian source bit for remap bit k (k = 0 is the MSB of the field)
  function automatic int remapSrc(input int k);
    if (k == 0) return 6;
    if (k == 1) return 8;
    return k + 8;
  endfunction
endpackage

// File: rtl/vec_prefix_dec.sv
module vec_prefix_dec
  import vec_prefix_pkg::*;
(
  input  logic [INST_W-1:0] instWord,
  output logic              isPrefix,
  output logic [RM_W-1:0]   remapField
);
  logic [OPC_W-1:0] majorOpc;
  logic idBitA;
  logic idBitB;

  assign majorOpc = instWord[INST_W-1 -: OPC_W];
  assign idBitA   = instWord[beIdx(INST_W, 7)];
  assign idBitB   = instWord[beIdx(INST_W, 9)];
  assign isPrefix = (majorOpc == PREFIX_OPC) && idBitA && idBitB;

  for (genvar k = 0; k < RM_W; k++) begin : g_remap
    assign remapField[RM_W-1-k] = instWord[beIdx(INST_W, remapSrc(k))];
  end
endmodule

// File: rtl/vec_prefix_ctrl.sv
module vec_prefix_ctrl
  import vec_prefix_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       isPrefix,
  input  logic       lenIsZero,
  input  logic       atLast,
  input  logic       retireValid,
  input  logic       destIsVector,
  input  logic       swWrEn,
  output seqStrobe_t strobe,
  output logic       holdPc,
  output logic       wideStep
);
  logic skipInst;

  assign skipInst = isPrefix && lenIsZero;
  assign holdPc   = isPrefix && !lenIsZero && destIsVector && !atLast;
  assign wideStep = isPrefix;

  always_comb begin
    strobe           = '0;
    strobe.swLoad    = swWrEn;
    strobe.stepInc   = retireValid && holdPc && !swWrEn;
    strobe.stepClear = retireValid && !holdPc && !skipInst && !swWrEn;
  end

  // R8: a software write suppresses every loop strobe
  p_sw_wins_r8: assert property (@(posedge clk) disable iff (rst)
    swWrEn |-> !(strobe.stepInc || strobe.stepClear));

  // R4: a skipped prefix never moves the step counter
  p_skip_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (isPrefix && lenIsZero) |-> !(strobe.stepInc || strobe.stepClear));
endmodule

// File: rtl/vec_prefix_datapath.sv
module vec_prefix_datapath
  import vec_prefix_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PC_W-1:0]    curPc,
  input  seqStrobe_t         strobe,
  input  logic               holdPc,
  input  logic               wideStep,
  input  logic [STATE_W-1:0] swWrData,
  output logic [PC_W-1:0]    nextPc,
  output logic [STATE_W-1:0] stateWord,
  output logic               lenIsZero,
  output logic               atLast
);
  localparam logic [PC_W-1:0] STEP_NARROW = PC_W'(4);
  localparam logic [PC_W-1:0] STEP_WIDE   = PC_W'(8);

  loopState_t stateQ;
  loopState_t stateD;

  always_comb begin
    stateD = stateQ;
    if (strobe.swLoad)         stateD = loopState_t'(swWrData);
    else if (strobe.stepInc)   stateD.srcStep = stateQ.srcStep + FLD_W'(1);
    else if (strobe.stepClear) stateD.srcStep = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= '0;
    else     stateQ <= stateD;
  end

  assign lenIsZero = (stateQ.len == '0);
  assign atLast    = (stateQ.srcStep == stateQ.len - FLD_W'(1));
  assign stateWord = stateQ;
  assign nextPc    = holdPc ? curPc : (curPc + (wideStep ? STEP_WIDE : STEP_NARROW));

  // R9: reset clears the state
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (stateQ == '0));

  // R8: a software write lands verbatim
  p_sw_load_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.swLoad |=> (stateWord == $past(swWrData)));

  // R5: a repeated element advances the source step by one
  p_step_inc_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.stepInc |=> (stateQ.srcStep == $past(stateQ.srcStep) + FLD_W'(1)));

  // R6: leaving the loop zeroes the source step and keeps the length
  p_step_clear_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.stepClear |=> (stateQ.srcStep == '0) && $stable(stateQ.len));

  // R9: with no strobe the state holds
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe == '0) |=> $stable(stateQ));
endmodule

// File: rtl/vec_prefix_seq.sv
module vec_prefix_seq
  import vec_prefix_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instWord,
  input  logic [PC_W-1:0] curPc,
  input  logic            retireValid,
  input  logic            destIsVector,
  input  logic            swWrEn,
  input  logic [31:0]     swWrData,
  output logic [PC_W-1:0] nextPc,
  output logic            isPrefix,
  output logic [23:0]     remapField,
  output logic [31:0]     loopState
);
  seqStrobe_t strobe;
  logic holdPc;
  logic wideStep;
  logic lenIsZero;
  logic atLast;

  vec_prefix_dec u_dec (
    .instWord   (instWord),
    .isPrefix   (isPrefix),
    .remapField (remapField)
  );

  vec_prefix_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .isPrefix     (isPrefix),
    .lenIsZero    (lenIsZero),
    .atLast       (atLast),
    .retireValid  (retireValid),
    .destIsVector (destIsVector),
    .swWrEn       (swWrEn),
    .strobe       (strobe),
    .holdPc       (holdPc),
    .wideStep     (wideStep)
  );

  vec_prefix_datapath #(.PC_W(PC_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .curPc     (curPc),
    .strobe    (strobe),
    .holdPc    (holdPc),
    .wideStep  (wideStep),
    .swWrData  (swWrData),
    .nextPc    (nextPc),
    .stateWord (loopState),
    .lenIsZero (lenIsZero),
    .atLast    (atLast)
  );

  // R3: a plain word always steps by four
  p_narrow_step_r3: assert property (@(posedge clk) disable iff (rst)
    !isPrefix |-> (nextPc == curPc + PC_W'(4)));

  // R1: a prefix can only come from the expected major opcode
  p_prefix_opc_r1: assert property (@(posedge clk) disable iff (rst)
    isPrefix |-> (instWord[31:26] == 6'd1));
endmodule

// File: tb/vec_prefix_seq_tb.sv
module vec_prefix_seq_tb;
  localparam int PC_W = 64;

  logic            clk = 1'b0;
  logic            rst;
  logic [31:0]     instWord;
  logic [PC_W-1:0] curPc;
  logic            retireValid;
  logic            destIsVector;
  logic            swWrEn;
  logic [31:0]     swWrData;
  logic [PC_W-1:0] nextPc;
  logic            isPrefix;
  logic [23:0]     remapField;
  logic [31:0]     loopState;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] model = '0;

  always #4 clk = ~clk;

  vec_prefix_seq #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst(rst), .instWord(instWord), .curPc(curPc),
    .retireValid(retireValid), .destIsVector(destIsVector),
    .swWrEn(swWrEn), .swWrData(swWrData), .nextPc(nextPc),
    .isPrefix(isPrefix), .remapField(remapField), .loopState(loopState)
  );

  function automatic logic fPrefix(input logic [31:0] w);
    return (w[31:26] == 6'b000001) && w[24] && w[22];
  endfunction

  function automatic logic [23:0] fRemap(input logic [31:0] w);
    return {w[25], w[23], w[21:0]};
  endfunction

  function automatic logic [6:0] fLen(input logic [31:0] s);
    return s[24:18];
  endfunction

  function automatic logic [6:0] fSrc(input logic [31:0] s);
    return s[17:11];
  endfunction

  function automatic logic [31:0] mkState(input logic [6:0] mx, input logic [6:0] ln,
      input logic [6:0] src, input logic [6:0] dst, input logic [1:0] sub, input logic [1:0] aux);
    return {mx, ln, src, dst, sub, aux};
  endfunction

  function automatic logic fHold(input logic [31:0] w, input logic [31:0] s, input logic dv);
    return fPrefix(w) && fLen(s) != 0 && dv && (fSrc(s) != fLen(s) - 7'd1);
  endfunction

  function automatic logic [PC_W-1:0] fNext(input logic [31:0] w, input logic [PC_W-1:0] pc,
      input logic [31:0] s, input logic dv);
    if (fHold(w, s, dv)) return pc;
    return pc + (fPrefix(w) ? 64'd8 : 64'd4);
  endfunction

  function automatic logic [31:0] fUpdate(input logic [31:0] w, input logic [31:0] s,
      input logic ret, input logic dv, input logic sw, input logic [31:0] sd);
    logic [31:0] r;
    r = s;
    if (sw) r = sd;
    else if (ret) begin
      if (fPrefix(w) && fLen(s) == 0) r = s;
      else if (fHold(w, s, dv)) r[17:11] = fSrc(s) + 7'd1;
      else r[17:11] = 7'd0;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, then state after the edge
  task automatic step(input logic [31:0] w, input logic [PC_W-1:0] pc, input logic ret,
      input logic dv, input logic sw, input logic [31:0] sd, input string stTag);
    logic [31:0] nxt;
    string pcTag;
    @(negedge clk);
    instWord = w; curPc = pc; retireValid = ret; destIsVector = dv;
    swWrEn = sw; swWrData = sd;
    #1;
    chk("R1 isPrefix", {63'd0, isPrefix}, {63'd0, fPrefix(w)});
    chk("R2 remapField", {40'd0, remapField}, {40'd0, fRemap(w)});
    if (fPrefix(w) && fLen(model) == 0) pcTag = "R4 nextPc";
    else if (fHold(w, model, dv)) pcTag = "R5 nextPc";
    else pcTag = "R3 nextPc";
    chk(pcTag, nextPc, fNext(w, pc, model, dv));
    nxt = fUpdate(w, model, ret, dv, sw, sd);
    @(posedge clk);
    #1;
    model = nxt;
    chk(stTag, {32'd0, loopState}, {32'd0, model});
  endtask

  function automatic logic [31:0] mkPrefix(input logic [31:0] r);
    logic [31:0] w;
    w = r;
    w[31:26] = 6'b000001;
    w[24] = 1'b1;
    w[22] = 1'b1;
    return w;
  endfunction

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] pw;
    logic [31:0] st;
    void'($urandom(32'd4242));
    rst = 1; instWord = 0; curPc = 0; retireValid = 0; destIsVector = 0;
    swWrEn = 1; swWrData = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset wins over a software write
    chk("R9 reset state", {32'd0, loopState}, 64'd0);
    @(negedge clk);
    rst = 0; swWrEn = 0;

    // R1: near misses, one identifying bit flipped
    pw = mkPrefix(32'h0000_0000);
    step(pw, 64'h1000, 0, 0, 0, 0, "R9 idle hold");
    for (int n = 0; n < 10; n++) begin
      if (n == 6 || n == 8) continue;
      step(pw ^ (32'h8000_0000 >> n), 64'h1000, 0, 0, 0, 0, "R9 idle hold");
    end
    // R2: alternating patterns
    step(mkPrefix(32'hAAAA_AAAA), 64'h2000, 0, 0, 0, 0, "R9 idle hold");
    step(mkPrefix(32'h5555_5555), 64'h2000, 0, 0, 0, 0, "R9 idle hold");
    step(32'h0280_0000, 64'h2000, 0, 0, 0, 0, "R9 idle hold");

    // R7/R8: load VL=3 through the field layout, then run a full loop (R5, R6)
    st = mkState(7'd8, 7'd3, 7'd0, 7'd5, 2'd1, 2'd2);
    step(32'h0, 64'h3000, 0, 0, 1, st, "R8 sw write R7");
    pw = mkPrefix(32'h0012_3456);
    for (int e = 0; e < 3; e++)
      step(pw, 64'h4000, 1, 1, 0, 0, e < 2 ? "R5 step inc" : "R6 last clear");
    // R6: scalar destination ends the loop after one element
    step(pw, 64'h4000, 1, 0, 0, 0, "R6 scalar clear");
    // R4: VL=0 skip leaves state alone
    st = mkState(7'd8, 7'd0, 7'd2, 7'd1, 2'd0, 2'd0);
    step(32'h0, 64'h5000, 0, 0, 1, st, "R8 sw write");
    step(pw, 64'h5000, 1, 1, 0, 0, "R4 skip state");
    // R8: write during a looping retire wins
    st = mkState(7'd8, 7'd4, 7'd1, 7'd0, 2'd0, 2'd0);
    step(32'h0, 64'h6000, 0, 0, 1, st, "R8 sw write");
    step(pw, 64'h6000, 1, 1, 1, mkState(7'd1, 7'd2, 7'd0, 7'd3, 2'd3, 2'd1), "R8 sw priority");
    // R6: non-prefix retire clears the step
    step(32'h1234_5678, 64'h6000, 1, 1, 0, 0, "R6 plain clear");
    // R3: PC wrap
    step(pw, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0, 0, 0, "R9 idle hold");

    // mixed seeded random run
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      logic [PC_W-1:0] pc;
      logic ret, dv, sw;
      logic [31:0] sd;
      string tg;
      case ($urandom % 4)
        0: w = $urandom;
        1: w = mkPrefix($urandom) ^ (32'h8000_0000 >> ($urandom % 10));
        default: w = mkPrefix($urandom);
      endcase
      pc = {$urandom, $urandom} & ~64'h3;
      ret = ($urandom % 4) != 0;
      dv = ($urandom % 4) != 0;
      sw = ($urandom % 10) == 0;
      st = $urandom;
      st[24:18] = 7'($urandom % 6);
      st[17:11] = 7'($urandom % 6);
      sd = st;
      if (sw) tg = "R8 rand write";
      else if (!ret) tg = "R9 rand hold";
      else if (fPrefix(w) && fLen(model) == 0) tg = "R4 rand skip";
      else if (fHold(w, model, dv)) tg = "R5 rand inc";
      else tg = "R6 rand clear";
      step(w, pc, ret, dv, sw, sd, tg);
    end
    finishRun();
  end
endmodule